// File: doc/BRIEF.md
# Ordered retirement and exception arbiter

This block keeps an in-order record of every instruction that has been dispatched but not yet retired. Each record notes the instruction address, whether it has reached writeback and whether writeback reported a fault. Records leave only from the oldest end. At most two leave in one cycle, and only while every older record is complete and fault-free. A fault on the oldest record is reported at once and the whole record set is discarded. As a result, faults that are detected out of order still reach the exception logic in program order, one at a time.

The block also arbitrates three asynchronous requests: a debug breakpoint request, an external interrupt and a timer (decrementer) request. The breakpoint has its own enable. The other two are gated by an interrupt-enable flag that the block holds. While a request is pending, dispatch is held off and the clean prefix drains. Then the oldest remaining record decides the outcome. If it carries a must-complete mark, the block waits for it. Otherwise the record set is flushed and the exception restarts at that record's address. If no record remains, the exception restarts at the current fetch address. Every exception is reported as a one-cycle pulse with a cause code and a registered restart address, and taking it clears the interrupt-enable flag.

Top module: `ordered_retire_arbiter`

## Requirements
- R1: After reset the record set is empty, `dispReady` is 1, `dispTag` is 0, `retireCount` is 0, `excValid` is 0 and `intEnable` is 0.
- R2: An accepted dispatch (`dispValid` and `dispReady` both 1) takes the tag shown on `dispTag`. Tags count upward and wrap modulo DEPTH. With DEPTH records outstanding, `dispReady` is 0 and no dispatch is taken.
- R3: A record retires only when it and every older record have completed writeback with no fault. `retireCount` gives how many retire in the current cycle (0, 1 or 2). A completion reported at one clock edge can first be counted in the cycle that follows that edge.
- R4: When the oldest record is complete with a fault, the next cycle shows `excValid`=1, cause 1 and the record's address. All records are discarded, so younger faults are never reported and `dispTag` returns to 0.
- R5: Cause codes are breakpoint 4, external interrupt 5 and timer 6, with that fixed priority (lowest code wins). A fault on the oldest record takes precedence over every asynchronous request.
- R6: External interrupt and timer requests are ignored while `intEnable` is 0. The breakpoint request is ignored while `bkptEnable` is 0.
- R7: While an enabled asynchronous request is pending, `dispReady` is 0, and complete fault-free records at the oldest end keep retiring before the exception is taken.
- R8: If the oldest remaining record is incomplete and marked must-complete, the exception waits until that record retires. The restart address is then that of the next remaining record, or `fetchPc` if none remains.
- R9: If the oldest remaining record is incomplete and not marked, the records are flushed and the restart address is that record's address, including completed younger records.
- R10: Every exception appears as a single-cycle pulse on `excValid`, one cycle after the decision. In the pulse cycle `intEnable` is 0. A one-cycle `intEnableSet` pulse sets `intEnable` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispPc | input | PC_W | Address of the dispatched instruction |
| dispMustDone | input | 1 | Dispatched instruction must complete before an asynchronous exception |
| dispReady | output | 1 | Dispatch can be accepted this cycle |
| dispTag | output | TAG_W | Tag given to the next accepted dispatch |
| wbValid | input | 1 | Writeback completion strobe |
| wbTag | input | TAG_W | Tag of the completing instruction |
| wbFault | input | 1 | Completion carries a synchronous fault |
| bkptReq | input | 1 | Breakpoint request |
| bkptEnable | input | 1 | Enable for the breakpoint request |
| extIrqReq | input | 1 | External interrupt request |
| decReq | input | 1 | Timer (decrementer) request |
| intEnableSet | input | 1 | Pulse that sets the interrupt-enable flag |
| fetchPc | input | PC_W | Restart address used when no record remains |
| intEnable | output | 1 | Interrupt-enable flag |
| retireCount | output | 2 | Records retiring this cycle |
| excValid | output | 1 | Exception pulse |
| excCause | output | 3 | Exception cause code, 0 outside a pulse |
| excPc | output | PC_W | Restart address of the last exception |

## Verification
A wrong head pointer or a stale completion bit shows at the ports within one or two cycles. Either `retireCount` becomes nonzero while an older record is still pending, or an exception reports the address of the wrong record. A missed flush shows on the very next dispatch, because `dispTag` is not 0. A record that is left behind either re-retires or blocks retirement in the following cycles. A wrong enable or priority decision shows as an unexpected or out-of-order pulse, or as a wrong cause code, one cycle after the request is seen. The scoreboard catches all of these because it expects each pulse in a known order.

// File: rtl/retire_arb_pkg.sv
`timescale 1ns/1ps
package retire_arb_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_SYNC = 3'd1,
    CAUSE_BKPT = 3'd4,
    CAUSE_EXT  = 3'd5,
    CAUSE_DEC  = 3'd6
  } causeT;

  // Strobes from the control to the record datapath
  typedef struct packed {
    logic       push;
    logic [1:0] retireCnt;
    logic       flush;
  } robCtrlT;

endpackage

// File: rtl/rob_datapath.sv
`timescale 1ns/1ps
module rob_datapath
  import retire_arb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  robCtrlT          ctrl,
  input  logic [PC_W-1:0]  dispPc,
  input  logic             dispMustDone,
  input  logic             wbValid,
  input  logic [TAG_W-1:0] wbTag,
  input  logic             wbFault,
  output logic [TAG_W-1:0] tailTag,
  output logic             full,
  output logic             h0Valid,
  output logic             h0Done,
  output logic             h0Fault,
  output logic             h0Must,
  output logic [PC_W-1:0]  h0Pc,
  output logic             h1Valid,
  output logic             h1Done,
  output logic             h1Fault
);

  logic [TAG_W-1:0] headPtr, tailPtr, head1Ptr;
  logic [CNT_W-1:0] count;
  logic [DEPTH-1:0] vldVec, doneVec, faultVec, mustVec;
  logic [PC_W-1:0]  pcArr [DEPTH];

  assign head1Ptr = headPtr + TAG_W'(1);

  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    localparam logic [TAG_W-1:0] IDX = TAG_W'(i);
    logic eVld, eDone, eFault, eMust;
    logic [PC_W-1:0] ePc;
    logic isPush, isWb, isRet;

    always_comb begin
      isPush = ctrl.push && (tailPtr == IDX);
      isWb   = wbValid && (wbTag == IDX) && eVld;
      isRet  = ((ctrl.retireCnt != 2'd0) && (headPtr == IDX)) ||
               ((ctrl.retireCnt == 2'd2) && (head1Ptr == IDX));
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        eVld   <= 1'b0;
        eDone  <= 1'b0;
        eFault <= 1'b0;
        eMust  <= 1'b0;
        ePc    <= '0;
      end else if (ctrl.flush) begin
        eVld <= 1'b0;
      end else begin
        if (isPush) begin
          eVld   <= 1'b1;
          eDone  <= 1'b0;
          eFault <= 1'b0;
          eMust  <= dispMustDone;
          ePc    <= dispPc;
        end
        if (isWb) begin
          eDone  <= 1'b1;
          eFault <= wbFault;
        end
        if (isRet) eVld <= 1'b0;
      end
    end

    assign vldVec[i]   = eVld;
    assign doneVec[i]  = eDone;
    assign faultVec[i] = eFault;
    assign mustVec[i]  = eMust;
    assign pcArr[i]    = ePc;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.flush) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      headPtr <= headPtr + TAG_W'(ctrl.retireCnt);
      tailPtr <= tailPtr + TAG_W'(ctrl.push);
      count   <= count + CNT_W'(ctrl.push) - CNT_W'(ctrl.retireCnt);
    end
  end

  always_comb begin
    tailTag = tailPtr;
    full    = (count == CNT_W'(DEPTH));
    h0Valid = vldVec[headPtr];
    h0Done  = doneVec[headPtr];
    h0Fault = faultVec[headPtr];
    h0Must  = mustVec[headPtr];
    h0Pc    = pcArr[headPtr];
    h1Valid = vldVec[head1Ptr];
    h1Done  = doneVec[head1Ptr];
    h1Fault = faultVec[head1Ptr];
  end

endmodule

// File: rtl/exc_control.sv
`timescale 1ns/1ps
module exc_control
  import retire_arb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            h0Valid,
  input  logic            h0Done,
  input  logic            h0Fault,
  input  logic            h0Must,
  input  logic [PC_W-1:0] h0Pc,
  input  logic            h1Valid,
  input  logic            h1Done,
  input  logic            h1Fault,
  input  logic            full,
  input  logic            dispValid,
  input  logic            bkptReq,
  input  logic            bkptEnable,
  input  logic            extIrqReq,
  input  logic            decReq,
  input  logic            intEnableSet,
  input  logic [PC_W-1:0] fetchPc,
  output robCtrlT         ctrl,
  output logic            dispReady,
  output logic            intEnable,
  output logic            excValid,
  output logic [2:0]      excCause,
  output logic [PC_W-1:0] excPc
);

  causeT asyncCause, takeCause;
  logic h0Clean, h1Clean, syncTake, asyncPend, asyncTake, take;
  logic [PC_W-1:0] restartPc;

  always_comb begin
    asyncCause = CAUSE_NONE;
    if (bkptReq && bkptEnable)      asyncCause = CAUSE_BKPT;
    else if (intEnable && extIrqReq) asyncCause = CAUSE_EXT;
    else if (intEnable && decReq)    asyncCause = CAUSE_DEC;
  end

  always_comb begin
    h0Clean   = h0Valid && h0Done && !h0Fault;
    h1Clean   = h1Valid && h1Done && !h1Fault;
    syncTake  = h0Valid && h0Done && h0Fault;
    asyncPend = (asyncCause != CAUSE_NONE);
    // head must be empty, or incomplete and not marked, before taking
    asyncTake = asyncPend && !syncTake && !h0Clean && !(h0Valid && h0Must);
    take      = syncTake || asyncTake;
    takeCause = syncTake ? CAUSE_SYNC : asyncCause;
    restartPc = h0Valid ? h0Pc : fetchPc;

    dispReady      = !full && !take && !asyncPend;
    ctrl.push      = dispValid && dispReady;
    ctrl.flush     = take;
    ctrl.retireCnt = 2'd0;
    if (!syncTake && h0Clean) ctrl.retireCnt = h1Clean ? 2'd2 : 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEnable <= 1'b0;
      excValid  <= 1'b0;
      excCause  <= CAUSE_NONE;
      excPc     <= '0;
    end else begin
      excValid <= take;
      excCause <= take ? takeCause : CAUSE_NONE;
      if (take) excPc <= restartPc;
      if (take)              intEnable <= 1'b0;
      else if (intEnableSet) intEnable <= 1'b1;
    end
  end

endmodule

// File: rtl/ordered_retire_arbiter.sv
`timescale 1ns/1ps
module ordered_retire_arbiter
  import retire_arb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic [PC_W-1:0]  dispPc,
  input  logic             dispMustDone,
  output logic             dispReady,
  output logic [TAG_W-1:0] dispTag,
  input  logic             wbValid,
  input  logic [TAG_W-1:0] wbTag,
  input  logic             wbFault,
  input  logic             bkptReq,
  input  logic             bkptEnable,
  input  logic             extIrqReq,
  input  logic             decReq,
  input  logic             intEnableSet,
  input  logic [PC_W-1:0]  fetchPc,
  output logic             intEnable,
  output logic [1:0]       retireCount,
  output logic             excValid,
  output logic [2:0]       excCause,
  output logic [PC_W-1:0]  excPc
);

  robCtrlT ctrlBus;
  logic full, h0Valid, h0Done, h0Fault, h0Must, h1Valid, h1Done, h1Fault;
  logic [PC_W-1:0] h0Pc;
  logic flushNow;

  assign retireCount = ctrlBus.retireCnt;
  assign flushNow    = ctrlBus.flush;

  rob_datapath #(.DEPTH(DEPTH), .PC_W(PC_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrlBus),
    .dispPc(dispPc), .dispMustDone(dispMustDone),
    .wbValid(wbValid), .wbTag(wbTag), .wbFault(wbFault),
    .tailTag(dispTag), .full(full),
    .h0Valid(h0Valid), .h0Done(h0Done), .h0Fault(h0Fault), .h0Must(h0Must), .h0Pc(h0Pc),
    .h1Valid(h1Valid), .h1Done(h1Done), .h1Fault(h1Fault)
  );

  exc_control #(.PC_W(PC_W)) uCtl (
    .clk(clk), .rstN(rstN),
    .h0Valid(h0Valid), .h0Done(h0Done), .h0Fault(h0Fault), .h0Must(h0Must), .h0Pc(h0Pc),
    .h1Valid(h1Valid), .h1Done(h1Done), .h1Fault(h1Fault),
    .full(full), .dispValid(dispValid),
    .bkptReq(bkptReq), .bkptEnable(bkptEnable), .extIrqReq(extIrqReq), .decReq(decReq),
    .intEnableSet(intEnableSet), .fetchPc(fetchPc),
    .ctrl(ctrlBus), .dispReady(dispReady), .intEnable(intEnable),
    .excValid(excValid), .excCause(excCause), .excPc(excPc)
  );

endmodule

// File: rtl/retire_arbiter_chk.sv
`timescale 1ns/1ps
module retire_arbiter_chk #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             dispValid,
  input logic             dispReady,
  input logic [TAG_W-1:0] dispTag,
  input logic             bkptReq,
  input logic             bkptEnable,
  input logic             extIrqReq,
  input logic             intEnable,
  input logic [1:0]       retireCount,
  input logic             excValid,
  input logic [2:0]       excCause,
  input logic             flushNow
);

  logic [CNT_W-1:0] occ;
  always_ff @(posedge clk) begin
    if (!rstN || flushNow) occ <= '0;
    else occ <= occ + CNT_W'(dispValid && dispReady) - CNT_W'(retireCount);
  end

  // R2
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == CNT_W'(DEPTH)) |-> !dispReady);

  // R4
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (dispTag == '0) && (retireCount == 2'd0));

  // R5
  timer_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCause == 3'd6) |-> $past(!(bkptReq && bkptEnable) && !extIrqReq));

  // R6
  gated_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && (excCause == 3'd5 || excCause == 3'd6)) |-> $past(intEnable));

  // R7
  pend_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bkptReq && bkptEnable) |-> !dispReady);

  // R10
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> !intEnable && (excCause != 3'd0));

endmodule

bind ordered_retire_arbiter retire_arbiter_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) uChk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady), .dispTag(dispTag),
  .bkptReq(bkptReq), .bkptEnable(bkptEnable), .extIrqReq(extIrqReq), .intEnable(intEnable),
  .retireCount(retireCount), .excValid(excValid), .excCause(excCause), .flushNow(flushNow)
);

// File: tb/tb_ordered_retire_arbiter.sv
`timescale 1ns/1ps
module tb_ordered_retire_arbiter;

  localparam int DEPTH = 8;
  localparam int PC_W  = 32;
  localparam int TAG_W = $clog2(DEPTH);

  logic clk = 1'b0, rstN = 1'b0;
  logic dispValid = 0, dispMustDone = 0, wbValid = 0, wbFault = 0;
  logic bkptReq = 0, bkptEnable = 0, extIrqReq = 0, decReq = 0, intEnableSet = 0;
  logic [PC_W-1:0] dispPc = '0, fetchPc = '0;
  logic [TAG_W-1:0] wbTag = '0;
  logic dispReady, intEnable, excValid;
  logic [TAG_W-1:0] dispTag;
  logic [1:0] retireCount;
  logic [2:0] excCause;
  logic [PC_W-1:0] excPc;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [2:0]      qCause [$];
  logic [PC_W-1:0] qPc [$];
  string           qReq [$];

  always #4 clk = ~clk;

  ordered_retire_arbiter #(.DEPTH(DEPTH), .PC_W(PC_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expectExc(input logic [2:0] c, input logic [PC_W-1:0] pc, input string req);
    qCause.push_back(c); qPc.push_back(pc); qReq.push_back(req);
  endtask

  // monitor: compare each exception pulse with the scoreboard
  always @(negedge clk) begin
    if (rstN && excValid) begin
      if (qCause.size() == 0) begin
        chk(1'b0, "R6", "unexpected exception cause", excCause, 0);
      end else begin
        automatic logic [2:0] c = qCause.pop_front();
        automatic logic [PC_W-1:0] p = qPc.pop_front();
        automatic string r = qReq.pop_front();
        chk(excCause == c, r, "exception cause", excCause, c);
        chk(excPc == p, r, "restart pc", excPc, p);
      end
    end
  end

  task automatic drained(input string req);
    chk(qCause.size() == 0, req, "expected exceptions outstanding", qCause.size(), 0);
  endtask

  task automatic dispatch(input logic [PC_W-1:0] pc, input logic must, input int expTag);
    dispValid = 1; dispPc = pc; dispMustDone = must;
    @(negedge clk);
    chk(dispReady == 1'b1, "R2", "dispReady on dispatch", dispReady, 1);
    chk(dispTag == TAG_W'(expTag), "R2", "dispatch tag", dispTag, expTag);
    tick();
    dispValid = 0; dispMustDone = 0;
  endtask

  task automatic writeback(input int tag, input logic fault);
    wbValid = 1; wbTag = TAG_W'(tag); wbFault = fault;
    tick();
    wbValid = 0; wbFault = 0;
  endtask

  task automatic enableIrq();
    intEnableSet = 1; tick(); intEnableSet = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(dispReady == 1, "R1", "dispReady", dispReady, 1);
    chk(dispTag == 0, "R1", "dispTag", dispTag, 0);
    chk(retireCount == 0, "R1", "retireCount", retireCount, 0);
    chk(excValid == 0, "R1", "excValid", excValid, 0);
    chk(intEnable == 0, "R1", "intEnable", intEnable, 0);
    tick();

    // R3 in-order retirement with out-of-order completion
    dispatch(32'h100, 0, 0);
    dispatch(32'h104, 0, 1);
    dispatch(32'h108, 0, 2);
    writeback(2, 0);
    writeback(1, 0);
    @(negedge clk);
    chk(retireCount == 0, "R3", "retire while oldest pending", retireCount, 0);
    tick();
    writeback(0, 0);
    @(negedge clk);
    chk(retireCount == 2, "R3", "dual retire", retireCount, 2);
    tick(); @(negedge clk);
    chk(retireCount == 1, "R3", "remaining retire", retireCount, 1);
    tick(); @(negedge clk);
    chk(retireCount == 0, "R3", "empty after retire", retireCount, 0);
    tick();

    // R4 faults reported in program order, one at a time
    dispatch(32'h200, 0, 3);
    dispatch(32'h204, 0, 4);
    dispatch(32'h208, 0, 5);
    expectExc(3'd1, 32'h204, "R4");
    writeback(5, 1);
    writeback(4, 1);
    writeback(3, 0);
    repeat (4) tick();
    @(negedge clk);
    chk(dispTag == 0, "R4", "tag after flush", dispTag, 0);
    drained("R4");
    tick();

    // R6 requests ignored while disabled
    extIrqReq = 1; decReq = 1; bkptReq = 1; bkptEnable = 0;
    repeat (4) tick();
    @(negedge clk);
    chk(dispReady == 1, "R6", "dispReady with masked requests", dispReady, 1);
    chk(excValid == 0, "R6", "no exception while masked", excValid, 0);
    tick();
    extIrqReq = 0; decReq = 0; bkptReq = 0;

    // R5 fixed priority and R10 enable handling
    fetchPc = 32'h300;
    enableIrq();
    @(negedge clk);
    chk(intEnable == 1, "R10", "intEnable after set", intEnable, 1);
    tick();
    bkptEnable = 1; bkptReq = 1; extIrqReq = 1; decReq = 1;
    expectExc(3'd4, 32'h300, "R5");
    tick();
    bkptReq = 0;
    @(negedge clk);
    chk(intEnable == 0, "R10", "intEnable cleared on entry", intEnable, 0);
    tick(); @(negedge clk);
    chk(excValid == 0, "R10", "single-cycle pulse", excValid, 0);
    expectExc(3'd5, 32'h300, "R5");
    enableIrq();
    tick();
    extIrqReq = 0;
    tick();
    expectExc(3'd6, 32'h300, "R5");
    enableIrq();
    tick();
    decReq = 0;
    repeat (2) tick();
    drained("R5");

    // R7/R8 drain then wait for a must-complete head
    enableIrq();
    dispatch(32'h400, 0, 0);
    dispatch(32'h404, 1, 1);
    dispatch(32'h408, 0, 2);
    writeback(0, 0);
    fetchPc = 32'h500;
    extIrqReq = 1;
    @(negedge clk);
    chk(dispReady == 0, "R7", "dispatch held while pending", dispReady, 0);
    chk(retireCount == 1, "R7", "clean prefix drains", retireCount, 1);
    repeat (2) tick();
    @(negedge clk);
    chk(retireCount == 0, "R8", "waiting on marked head", retireCount, 0);
    chk(excValid == 0, "R8", "no exception before head retires", excValid, 0);
    tick();
    writeback(2, 0);
    expectExc(3'd5, 32'h500, "R8");
    writeback(1, 0);
    @(negedge clk);
    chk(retireCount == 2, "R8", "marked head retires", retireCount, 2);
    tick();
    tick();
    extIrqReq = 0;
    repeat (2) tick();
    drained("R8");

    // R9 flush with unmarked incomplete head
    enableIrq();
    dispatch(32'h600, 0, 0);
    dispatch(32'h604, 0, 1);
    writeback(1, 0);
    expectExc(3'd6, 32'h600, "R9");
    decReq = 1;
    tick();
    decReq = 0;
    tick(); @(negedge clk);
    chk(dispTag == 0, "R9", "records flushed", dispTag, 0);
    chk(retireCount == 0, "R9", "flushed record not retired", retireCount, 0);
    tick();
    drained("R9");

    // R5 synchronous fault beats pending interrupt
    enableIrq();
    dispatch(32'h700, 1, 0);
    extIrqReq = 1;
    repeat (2) tick();
    @(negedge clk);
    chk(excValid == 0, "R5", "held by marked head", excValid, 0);
    tick();
    expectExc(3'd1, 32'h700, "R5");
    writeback(0, 1);
    tick();
    extIrqReq = 0;
    repeat (3) tick();
    drained("R5");

    // R2 full stall and tag wrap
    for (int i = 0; i < DEPTH; i++) dispatch(32'h800 + 32'(4 * i), 0, i);
    dispValid = 1; dispPc = 32'h900;
    @(negedge clk);
    chk(dispReady == 0, "R2", "stall when full", dispReady, 0);
    chk(dispTag == 0, "R2", "tag wrapped", dispTag, 0);
    tick();
    @(negedge clk);
    chk(dispTag == 0, "R2", "no dispatch while full", dispTag, 0);
    dispValid = 0;
    tick();
    expectExc(3'd1, 32'h800, "R4");
    writeback(0, 1);
    repeat (3) tick();
    drained("R4");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule